// File: doc/BRIEF.md
# E1 Timeslot Cell Mapper

This block carries a continuous stream of 53-octet ATM cells over a 2.048 Mbit/s E1 line of 32 octet timeslots per frame. It runs on the line bit clock. An internal free-running 256-bit frame counter produces a one-clock octet strobe every 8 clocks, a timeslot number and a frame-start strobe. Timeslot 0 carries an alternating alignment word. Timeslot 16 carries a fixed signalling octet set by a parameter. The other 30 timeslots carry cell octets in order. Cells run on across frame boundaries and are aligned only to octets.

On the transmit side a user source offers whole cells through a valid/ready octet interface. At every cell boundary the mapper either starts the offered user cell or, when none is offered, sends a complete idle cell, so the cell stream never breaks. On the receive side the mapper picks the octets of the payload timeslots out of an incoming octet-wide line and presents them, one pulse per octet, to a later cell delineation stage. Line coding, multiframing and clock recovery are handled elsewhere.

Top module: `e1_cell_mapper`

## Requirements
- R1: While `rstN` is low, `txOctet`, `txSlot`, `txCellStart`, `cellReady` and `rxValid` are 0. In the first clock after release, `frameStart` and `octetStrobe` are both high.
- R2: A frame lasts 256 clocks. `octetStrobe` is high on every 8th clock, starting at the clock of `frameStart`. `slotNum` counts the timeslots 0..31 in order and steps on each strobe.
- R3: Timeslot 0 carries 0x1B in the first frame after reset and 0x40 in the next. The two values then alternate frame by frame.
- R4: Timeslot 16 always carries the parameter `SIG_WORD`.
- R5: Cell octets fill timeslots 1..15 and 17..31 in that order. A cell that is not finished at timeslot 31 continues in timeslot 1 of the next frame. `txOctet` and `txSlot` are registered and change in the clock after `octetStrobe`.
- R6: An idle cell is the octet sequence 0x00, 0x00, 0x00, 0x01, 0x52, followed by 48 octets of 0x6A. It is sent whenever `cellValid` is low at a cell boundary.
- R7: At a cell boundary `cellReady` is high. If `cellValid` is high there, the offered octet becomes octet 0 of a user cell. `cellReady` then stays high on each of the next 52 payload strobes, and the 53 octets go out back to back with no idle octet between them. The source holds `cellValid` high for the whole cell.
- R8: `txCellStart` is high exactly with the first octet of every cell, whether user or idle. It therefore marks every 53rd payload octet, counting from the first payload octet after reset.
- R9: `cellReady` is high only on `octetStrobe` clocks of payload timeslots. It is low for octets 1..52 of an idle cell.
- R10: `rxOctet` is sampled in the clock whose bit phase (counter bits 2:0) equals 4, in payload timeslots only. `rxData` then holds that octet and `rxValid` pulses for one clock. Timeslots 0 and 16 produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellData | input | 8 | Octet offered by the user cell source |
| cellValid | input | 1 | Source has an octet (and, at a boundary, a whole cell) |
| cellReady | output | 1 | Mapper takes `cellData` at the next clock edge |
| frameStart | output | 1 | First clock of an E1 frame |
| octetStrobe | output | 1 | First clock of a timeslot |
| slotNum | output | 5 | Current timeslot number |
| txOctet | output | 8 | Transmit octet of the timeslot in `txSlot` |
| txSlot | output | 5 | Timeslot that `txOctet` belongs to |
| txCellStart | output | 1 | `txOctet` is the first octet of a cell |
| rxOctet | input | 8 | Received octet of the current timeslot |
| rxData | output | 8 | Last captured payload octet |
| rxValid | output | 1 | One-clock pulse for a new `rxData` |

## Verification
The hard corner is a source that becomes valid in the middle of an idle cell. A mapper that starts the user cell at once would cut the idle cell short, and one that waits a further cell would put an extra idle cell in front of the burst. The bench checks that the first user cell starts at exactly the next boundary and that the following cells run back to back. User cells longer than a frame's payload are compared octet by octet across the skip of timeslots 16 and 0. A mapper that counted those slots as payload, or restarted the cell at each frame, would corrupt the cell contents. On receive, a per-frame octet pattern shows a capture from slot 0 or 16, or a capture in the wrong timeslot, as a wrong or out-of-order value.

// File: rtl/e1map_pkg.sv
package e1map_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int SLOTS      = 32;
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int PH_W       = $clog2(SLOT_BITS);
  localparam int SLOT_W     = CNT_W - PH_W;
  localparam int CELL_LEN   = 53;
  localparam int HDR_LEN    = 5;
  localparam int IDX_W      = $clog2(CELL_LEN);

  localparam logic [SLOT_W-1:0] ALIGN_SLOT = '0;
  localparam logic [SLOT_W-1:0] SIG_SLOT   = SLOT_W'(SLOTS / 2);
  localparam logic [PH_W-1:0]   RX_PHASE   = PH_W'(SLOT_BITS / 2);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(CELL_LEN - 1);

  typedef logic [SLOT_BITS-1:0] octetT;

  localparam octetT FAS_WORD  = 8'h1B;
  localparam octetT NFAS_WORD = 8'h40;
  localparam octetT IDLE_TAG  = 8'h01;
  localparam octetT IDLE_HEC  = 8'h52;
  localparam octetT IDLE_FILL = 8'h6A;

  typedef enum logic [2:0] {
    SRC_ALIGN,
    SRC_NALIGN,
    SRC_SIG,
    SRC_USER,
    SRC_IDLE
  } srcE;

  // strobes from control to datapath
  typedef struct packed {
    logic              txLoad;
    srcE               src;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  cellIdx;
    logic              rxCapture;
  } strobeT;

  function automatic octetT idleOctet(input logic [IDX_W-1:0] idx);
    if (idx < IDX_W'(HDR_LEN - 2))       return '0;
    else if (idx == IDX_W'(HDR_LEN - 2)) return IDLE_TAG;
    else if (idx == IDX_W'(HDR_LEN - 1)) return IDLE_HEC;
    else                                 return IDLE_FILL;
  endfunction
endpackage

// File: rtl/e1map_ctrl.sv
module e1map_ctrl
  import e1map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellValid,
  output strobeT            strb,
  output logic              cellReady,
  output logic              frameStart,
  output logic              octetStrobe,
  output logic [SLOT_W-1:0] slotNum
);
  logic [CNT_W-1:0] bitCnt;
  logic [PH_W-1:0]  phase;
  logic             payloadSlot;
  logic             payLoad;
  logic             cellBoundary;
  logic             alignPhase;
  logic             userCell;
  logic [IDX_W-1:0] cellIdx;
  srcE              srcSel;

  assign phase        = bitCnt[PH_W-1:0];
  assign slotNum      = bitCnt[CNT_W-1:PH_W];
  assign octetStrobe  = (phase == '0);
  assign frameStart   = (bitCnt == '0);
  assign payloadSlot  = (slotNum != ALIGN_SLOT) && (slotNum != SIG_SLOT);
  assign payLoad      = octetStrobe && payloadSlot;
  assign cellBoundary = (cellIdx == '0);
  assign cellReady    = payLoad && (cellBoundary || userCell);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      alignPhase <= 1'b0;
      cellIdx    <= '0;
      userCell   <= 1'b0;
    end else begin
      bitCnt <= (bitCnt == CNT_W'(FRAME_BITS - 1)) ? '0 : bitCnt + 1'b1;
      if (frameStart) alignPhase <= ~alignPhase;
      if (payLoad) begin
        cellIdx <= (cellIdx == LAST_IDX) ? '0 : cellIdx + 1'b1;
        if (cellBoundary) userCell <= cellValid;
      end
    end
  end

  always_comb begin
    if (slotNum == ALIGN_SLOT)    srcSel = alignPhase ? SRC_NALIGN : SRC_ALIGN;
    else if (slotNum == SIG_SLOT) srcSel = SRC_SIG;
    else if (cellBoundary)        srcSel = cellValid ? SRC_USER : SRC_IDLE;
    else                          srcSel = userCell ? SRC_USER : SRC_IDLE;
  end

  always_comb begin
    strb.txLoad    = octetStrobe;
    strb.src       = srcSel;
    strb.slot      = slotNum;
    strb.cellIdx   = cellIdx;
    strb.rxCapture = (phase == RX_PHASE) && payloadSlot;
  end
endmodule

// File: rtl/e1map_dp.sv
module e1map_dp
  import e1map_pkg::*;
#(
  parameter octetT SIG_WORD = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  octetT             cellData,
  input  octetT             rxOctet,
  output octetT             txOctet,
  output logic [SLOT_W-1:0] txSlot,
  output logic              txCellStart,
  output octetT             rxData,
  output logic              rxValid
);
  octetT nextOctet;
  logic  nextStart;

  always_comb begin
    unique case (strb.src)
      SRC_ALIGN:  nextOctet = FAS_WORD;
      SRC_NALIGN: nextOctet = NFAS_WORD;
      SRC_SIG:    nextOctet = SIG_WORD;
      SRC_USER:   nextOctet = cellData;
      default:    nextOctet = idleOctet(strb.cellIdx);
    endcase
    nextStart = ((strb.src == SRC_USER) || (strb.src == SRC_IDLE)) && (strb.cellIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOctet     <= '0;
      txSlot      <= '0;
      txCellStart <= 1'b0;
      rxData      <= '0;
      rxValid     <= 1'b0;
    end else begin
      if (strb.txLoad) begin
        txOctet     <= nextOctet;
        txSlot      <= strb.slot;
        txCellStart <= nextStart;
      end
      rxValid <= strb.rxCapture;
      if (strb.rxCapture) rxData <= rxOctet;
    end
  end
endmodule

// File: rtl/e1_cell_mapper.sv
module e1_cell_mapper
  import e1map_pkg::*;
#(
  parameter logic [7:0] SIG_WORD = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cellData,
  input  logic       cellValid,
  output logic       cellReady,
  output logic       frameStart,
  output logic       octetStrobe,
  output logic [4:0] slotNum,
  output logic [7:0] txOctet,
  output logic [4:0] txSlot,
  output logic       txCellStart,
  input  logic [7:0] rxOctet,
  output logic [7:0] rxData,
  output logic       rxValid
);
  strobeT strb;

  e1map_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cellValid  (cellValid),
    .strb       (strb),
    .cellReady  (cellReady),
    .frameStart (frameStart),
    .octetStrobe(octetStrobe),
    .slotNum    (slotNum)
  );

  e1map_dp #(.SIG_WORD(SIG_WORD)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cellData   (cellData),
    .rxOctet    (rxOctet),
    .txOctet    (txOctet),
    .txSlot     (txSlot),
    .txCellStart(txCellStart),
    .rxData     (rxData),
    .rxValid    (rxValid)
  );
endmodule

// File: rtl/e1map_chk.sv
module e1map_chk
  import e1map_pkg::*;
#(
  parameter octetT SIG_WORD = 8'hFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              octetStrobe,
  input logic              cellReady,
  input logic              txCellStart,
  input logic              rxValid,
  input logic [SLOT_W-1:0] slotNum,
  input logic [SLOT_W-1:0] txSlot,
  input octetT             txOctet
);
  logic [CNT_W:0] gap;
  logic [IDX_W:0] payCnt;
  logic           seenFrame, loadSeen, startSeen, haveAlign;
  logic           newPay, newAlign;
  octetT          lastAlign;

  assign newPay   = loadSeen && (txSlot != ALIGN_SLOT) && (txSlot != SIG_SLOT);
  assign newAlign = loadSeen && (txSlot == ALIGN_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap       <= '0;
      payCnt    <= '0;
      seenFrame <= 1'b0;
      loadSeen  <= 1'b0;
      startSeen <= 1'b0;
      haveAlign <= 1'b0;
      lastAlign <= '0;
    end else begin
      gap      <= frameStart ? (CNT_W+1)'(1) : gap + 1'b1;
      loadSeen <= octetStrobe;
      if (frameStart) seenFrame <= 1'b1;
      if (newPay) begin
        payCnt <= txCellStart ? (IDX_W+1)'(1) : payCnt + 1'b1;
        if (txCellStart) startSeen <= 1'b1;
      end
      if (newAlign) begin
        lastAlign <= txOctet;
        haveAlign <= 1'b1;
      end
    end
  end

  p_frame_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && seenFrame |-> gap == (CNT_W+1)'(FRAME_BITS));
  p_align_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    newAlign |-> (txOctet == FAS_WORD) || (txOctet == NFAS_WORD));
  p_align_alt_r3: assert property (@(posedge clk) disable iff (!rstN)
    newAlign && haveAlign |-> txOctet != lastAlign);
  p_sig_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadSeen && (txSlot == SIG_SLOT) |-> txOctet == SIG_WORD);
  p_first_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    newPay && !startSeen |-> txCellStart);
  p_cell_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    newPay && startSeen |-> txCellStart == (payCnt == (IDX_W+1)'(CELL_LEN)));
  p_ready_slot_r9: assert property (@(posedge clk) disable iff (!rstN)
    cellReady |-> octetStrobe && (slotNum != ALIGN_SLOT) && (slotNum != SIG_SLOT));
  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  p_rx_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(slotNum) != ALIGN_SLOT) && ($past(slotNum) != SIG_SLOT));
endmodule

bind e1_cell_mapper e1map_chk #(.SIG_WORD(SIG_WORD)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .octetStrobe(octetStrobe),
  .cellReady  (cellReady),
  .txCellStart(txCellStart),
  .rxValid    (rxValid),
  .slotNum    (slotNum),
  .txSlot     (txSlot),
  .txOctet    (txOctet)
);

// File: tb/e1_cell_mapper_tb.sv
module e1_cell_mapper_tb;
  localparam logic [7:0] SIG = 8'hA5;
  localparam int NCELL = 5;
  localparam int CLEN  = 53;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cellData = '0;
  logic       cellValid = 1'b0;
  logic       cellReady, frameStart, octetStrobe, txCellStart, rxValid;
  logic [4:0] slotNum, txSlot;
  logic [7:0] txOctet, rxData;
  logic [7:0] rxOctet = '0;

  int checks = 0;
  int errors = 0;

  // monitor logs
  logic [7:0] payOct [0:2047];
  logic       payStart [0:2047];
  logic       payRdy [0:2047];
  logic [4:0] paySlot [0:2047];
  int         payFrm [0:2047];
  logic [7:0] alignLog [0:63];
  logic [7:0] sigLog [0:63];
  logic [7:0] rxLog [0:255];
  int payN = 0, alignN = 0, sigN = 0, rxN = 0, txFrame = 0, rxFrame = 0;
  bit loadPend = 0, rdyPend = 0;

  // source
  logic [7:0] srcBuf [0:NCELL*CLEN-1];
  int  srcLen = 0, srcPos = 0, enIdx = -1;
  bit  srcEn = 0, srcLive = 0, takePend = 0;

  always #5 clk = ~clk;

  e1_cell_mapper #(.SIG_WORD(SIG)) u_dut (
    .clk(clk), .rstN(rstN), .cellData(cellData), .cellValid(cellValid),
    .cellReady(cellReady), .frameStart(frameStart), .octetStrobe(octetStrobe),
    .slotNum(slotNum), .txOctet(txOctet), .txSlot(txSlot), .txCellStart(txCellStart),
    .rxOctet(rxOctet), .rxData(rxData), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (loadPend) begin
        if (txSlot == 5'd0) begin
          if (alignN < 64) alignLog[alignN] = txOctet;
          alignN++;
          txFrame++;
        end else if (txSlot == 5'd16) begin
          if (sigN < 64) sigLog[sigN] = txOctet;
          sigN++;
        end else if (payN < 2048) begin
          payOct[payN] = txOctet; payStart[payN] = txCellStart;
          payRdy[payN] = rdyPend; paySlot[payN] = txSlot; payFrm[payN] = txFrame;
          payN++;
        end
      end
      if (rxValid && rxN < 256) begin rxLog[rxN] = rxData; rxN++; end
      if (frameStart) rxFrame++;
      if (takePend) srcPos++;
    end
    loadPend = octetStrobe;
    rdyPend  = cellReady;
    if (srcEn && !srcLive) begin srcLive = 1; enIdx = payN; end
    cellValid = rstN && srcEn && (srcPos < srcLen);
    cellData  = cellValid ? srcBuf[srcPos] : 8'h00;
    takePend  = rstN && cellReady && cellValid;
    rxOctet   = {rxFrame[2:0], slotNum};
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] idleAt(input int i);
    if (i < 3) return 8'h00;
    if (i == 3) return 8'h01;
    if (i == 4) return 8'h52;
    return 8'h6A;
  endfunction

  function automatic logic [4:0] payloadSlotAt(input int k);
    int j = k % 30;
    return (j < 15) ? 5'(j + 1) : 5'(j + 2);
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) step();
    chk(txOctet == 8'h00 && txSlot == 5'd0 && !txCellStart, "R1", "tx outputs in reset", txOctet, 0);
    chk(!cellReady && !rxValid, "R1", "ready/rxValid in reset", {cellReady, rxValid}, 0);
    @(negedge clk); #2; rstN = 1'b1;
    chk(frameStart && octetStrobe, "R1", "frame/octet strobe after release", {frameStart, octetStrobe}, 3);
    step();
    chk(txSlot == 5'd0 && txOctet == 8'h1B, "R3", "first slot0 after reset", txOctet, 8'h1B);
  endtask

  task automatic t_timing();
    int gap = 0, strobes = 0, bad = 0;
    while (!frameStart) step();
    forever begin
      step(); gap++;
      if (frameStart) break;
      if (octetStrobe != (gap % 8 == 0)) bad++;
      if (octetStrobe) begin
        strobes++;
        if (slotNum != 5'(strobes)) bad++;
      end
    end
    chk(gap == 256, "R2", "frame length in clocks", gap, 256);
    chk(strobes == 31, "R2", "strobes between frame starts", strobes, 31);
    chk(bad == 0, "R2", "strobe phase / slot count errors", bad, 0);
  endtask

  task automatic t_idle();
    int badO = 0, badS = 0, badR = 0, badT = 0;
    while (alignN < 3) step();
    chk(alignLog[0] == 8'h1B, "R3", "slot0 frame 0", alignLog[0], 8'h1B);
    chk(alignLog[1] == 8'h40, "R3", "slot0 frame 1", alignLog[1], 8'h40);
    chk(alignLog[2] == 8'h1B, "R3", "slot0 frame 2", alignLog[2], 8'h1B);
    for (int k = 0; k < sigN && k < 64; k++)
      chk(sigLog[k] == SIG, "R4", "slot16 octet", sigLog[k], SIG);
    for (int k = 0; k < payN; k++) begin
      if (payOct[k] != idleAt(k % CLEN)) badO++;
      if (payStart[k] != (k % CLEN == 0)) badS++;
      if (payRdy[k] != (k % CLEN == 0)) badR++;
      if (paySlot[k] != payloadSlotAt(k)) badT++;
    end
    chk(payN >= 60, "R6", "payload octets seen", payN, 60);
    chk(badO == 0, "R6", "idle cell octet mismatches", badO, 0);
    chk(badS == 0, "R8", "cell start flag mismatches", badS, 0);
    chk(badR == 0, "R9", "ready outside idle boundary", badR, 0);
    chk(badT == 0, "R5", "payload slot order mismatches", badT, 0);
  endtask

  task automatic t_user();
    int c, badO = 0, badS = 0, badR = 0, span = 0, badI = 0;
    for (int u = 0; u < NCELL; u++)
      for (int i = 0; i < CLEN; i++)
        srcBuf[u*CLEN + i] = (i == 0) ? 8'(8'h10 + u) : 8'(u*37 + i*5 + 3);
    srcLen = NCELL * CLEN;
    srcPos = 0;
    while (payN % CLEN != 20) step();
    srcEn = 1;
    while (srcPos < srcLen) step();
    while (payN < enIdx + CLEN * (NCELL + 2)) step();
    c = ((enIdx + CLEN - 1) / CLEN) * CLEN;
    for (int i = 0; i < CLEN; i++)
      if (payOct[c - CLEN + i] != idleAt(i)) badI++;
    chk(badI == 0, "R7", "idle cell before burst left whole", badI, 0);
    chk(payStart[c] && payOct[c] == 8'h10, "R7", "first user cell at next boundary", payOct[c], 8'h10);
    for (int u = 0; u < NCELL; u++) begin
      for (int i = 0; i < CLEN; i++) begin
        int k = c + u*CLEN + i;
        if (payOct[k] != srcBuf[u*CLEN + i]) badO++;
        if (payStart[k] != (i == 0)) badS++;
        if (!payRdy[k]) badR++;
      end
      if (payFrm[c + u*CLEN] != payFrm[c + u*CLEN + CLEN - 1]) span++;
    end
    chk(badO == 0, "R7", "user cell octet mismatches", badO, 0);
    chk(badR == 0, "R7", "ready low inside user cell", badR, 0);
    chk(badS == 0, "R8", "start flags in user burst", badS, 0);
    chk(span > 0, "R5", "user cells spanning a frame boundary", span, 1);
    badI = 0;
    for (int i = 0; i < CLEN; i++) begin
      int k = c + NCELL*CLEN + i;
      if (payOct[k] != idleAt(i) || payRdy[k] != (i == 0)) badI++;
    end
    chk(badI == 0, "R6", "idle cell after burst", badI, 0);
    srcEn = 0;
  endtask

  task automatic t_rx();
    int base, badV = 0;
    step();
    while (!frameStart) step();
    rxN = 0;
    base = rxFrame;
    while (rxN < 60) step();
    for (int k = 0; k < 60; k++) begin
      int f = base + k / 30;
      logic [7:0] e = {3'(f), payloadSlotAt(k)};
      if (rxLog[k] != e) begin
        badV++;
        if (badV == 1) chk(0, "R10", "first receive octet mismatch", rxLog[k], e);
      end
    end
    chk(badV == 0, "R10", "receive octet mismatches", badV, 0);
    step();
    chk(!rxValid || rxN <= 61, "R10", "capture count", rxN, 60);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_idle();
    t_user();
    t_rx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule